// File: doc/BRIEF.md
# Channel Frame Sync Detector and Protector

This block sits behind the bit-clock recovery of an optical-disc channel decoder. It takes the recovered, transition-decoded channel bits one at a time, qualified by a bit enable. It finds the frame sync word and keeps a bit counter that marks where each frame starts. From that counter it cuts the frame into fixed-width channel symbols and hands them to the symbol demodulator.

Sync words are only trusted near the place where the running count expects them. A sync word that is missing there is replaced by a synthetic frame start, so the symbol cutting carries on. A sync word that turns up somewhere else moves the frame timing only after it has been seen at that same place in several frames in a row. A long run of synthetic starts drops the lock, and the search window then opens to the whole frame.

Top module: `fsync_framer`

## Requirements
- R1: During and directly after reset, `locked`, `frame_start`, `frame_inserted` and `sym_valid` are all low.
- R2: `bit_in` is taken only in cycles with `bit_en` high. Values driven while `bit_en` is low never produce a strobe, a symbol or a change of lock.
- R3: The sync word is 24 bits, listed oldest first: 1, ten 0s, 1, ten 0s, 1, 0 (two 11-bit runs between transitions). While unlocked it is accepted at any bit position. Acceptance raises `frame_start` (with `frame_inserted` low) and sets `locked`.
- R4: While locked, a sync word is accepted when its last bit falls within ±`SYNC_WIN` bits of frame bit index 23. The frame count is then re-timed to it, so the following symbols line up with the new position.
- R5: A frame is `SYNC_BITS + MERGE_BITS + NUM_SYMS*(SYM_BITS+MERGE_BITS)` bits long (588 by default). While locked, if no sync is accepted by the last bit of the window, `frame_start` and `frame_inserted` pulse together on that bit and the count keeps running unchanged.
- R6: After the 24 sync bits and 3 merging bits come `NUM_SYMS` slots. Each slot is a 14-bit symbol followed by 3 merging bits. `sym_word` holds the first-received bit as its MSB. `sym_idx` counts 0 to `NUM_SYMS-1`. `sym_valid` pulses one cycle after the enabled bit that completes the symbol.
- R7: `sym_sub` is high with the symbol of index 0 and low at all other times.
- R8: The `LOSS_LIMIT`-th synthetic start in a row clears `locked`. Symbols are emitted only while locked. No synthetic starts are made while unlocked.
- R9: While locked, a sync word outside the window moves the frame timing only on its `CONFIRM`-th sighting at the same count, one frame apart. The move raises `frame_start` with `frame_inserted` low. A frame in which that count passes without a sighting restarts the confirmation.
- R10: `frame_start` and `frame_inserted` are registered one cycle after the enabled bit that causes them. `frame_inserted` never appears without `frame_start`, and `frame_start` never coincides with `sym_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Transition-decoded channel bit |
| frame_start | output | 1 | Frame boundary strobe, real or synthetic |
| frame_inserted | output | 1 | Boundary was synthesised (no sync seen) |
| locked | output | 1 | Frame timing is locked |
| sym_valid | output | 1 | Symbol word valid strobe |
| sym_word | output | SYM_BITS | Channel symbol, first bit in MSB |
| sym_idx | output | $clog2(NUM_SYMS) | Symbol index within frame |
| sym_sub | output | 1 | Symbol is the frame's first (subcode) symbol |

## Verification
The bench builds the framer with `NUM_SYMS` = 4, which gives a 95-bit frame, with `LOSS_LIMIT` = 6, `CONFIRM` = 3 and the default window of 2. Frames are cheap at this size, so the bench can sweep every in-window offset on both sides and the first out-of-window offset. It can also drive a full run to loss of lock and a full forward-confirmation sequence, each with and without an interrupting frame. Symbol words are generated arithmetically from a frame seed and the slot index, and they can never contain the sync run length. The bench therefore knows the exact word, index and subcode flag for every slot the framer should emit.

// File: rtl/fsync_pkg.sv
package fsync_pkg;

    // Two maximal 11-bit runs between transitions, oldest bit at the MSB.
    localparam int          DEF_SYNC_BITS    = 24;
    localparam logic [23:0] DEF_SYNC_PATTERN = 24'b1000_0000_0001_0000_0000_0010;

    // Per-bit framing decision handed from the timing core to the top.
    typedef struct packed {
        logic take;    // real sync accepted (open, windowed or confirmed move)
        logic insert;  // synthetic boundary at window close
    } fsync_evt_t;

    function automatic int frame_len(input int sync_bits, input int merge_bits,
                                     input int sym_bits, input int n_syms);
        return sync_bits + merge_bits + n_syms * (sym_bits + merge_bits);
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fsync_shifter.sv
module fsync_shifter
    import fsync_pkg::*;
#(
    parameter int                   SYNC_BITS = 24,
    parameter int                   SYM_BITS  = 14,
    parameter logic [SYNC_BITS-1:0] PATTERN   = DEF_SYNC_PATTERN
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bit_en,
    input  logic                bit_in,
    output logic                sync_hit,
    output logic [SYM_BITS-1:0] word_now
);
    localparam int SR_W = max2(SYNC_BITS, SYM_BITS) - 1;

    logic [SR_W-1:0] sr_q;
    logic [SR_W:0]   view;

    // View including the bit being presented this cycle.
    assign view = {sr_q, bit_in};

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0;
        end else if (bit_en) begin
            sr_q <= view[SR_W-1:0];
        end
    end

    assign sync_hit = bit_en && (view[SYNC_BITS-1:0] == PATTERN);
    assign word_now = view[SYM_BITS-1:0];

endmodule

// File: rtl/fsync_timing.sv
module fsync_timing
    import fsync_pkg::*;
#(
    parameter int FRAME_BITS = 588,
    parameter int SYNC_BITS  = 24,
    parameter int SYNC_WIN   = 2,
    parameter int LOSS_LIMIT = 8,
    parameter int CONFIRM    = 3,
    parameter int CW         = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bit_en,
    input  logic          sync_hit,
    output logic [CW-1:0] pos,
    output fsync_evt_t    evt,
    output logic          locked
);
    localparam int SYNC_END = SYNC_BITS - 1;
    localparam int WIN_LO   = SYNC_END - SYNC_WIN;
    localparam int WIN_HI   = SYNC_END + SYNC_WIN;
    localparam int MW       = $clog2(LOSS_LIMIT + 1);
    localparam int FW       = $clog2(CONFIRM + 1);

    logic [CW-1:0] cnt_q, nxt, cand_pos_q;
    logic [FW-1:0] cand_n_q;
    logic [MW-1:0] miss_q;
    logic          cand_v_q, seen_q, locked_q;
    logic          in_win, win_close;
    logic          hit_open, hit_win, hit_out, cand_same, fwd_move;
    logic          take, insert, shifted;

    always_comb begin
        nxt       = (cnt_q == CW'(FRAME_BITS - 1)) ? '0 : cnt_q + 1'b1;
        in_win    = (nxt >= CW'(WIN_LO)) && (nxt <= CW'(WIN_HI));
        win_close = (nxt == CW'(WIN_HI));
        hit_open  = sync_hit && !locked_q;
        hit_win   = sync_hit && locked_q && in_win;
        hit_out   = sync_hit && locked_q && !in_win;
        cand_same = hit_out && cand_v_q && (nxt == cand_pos_q);
        fwd_move  = cand_same && (cand_n_q == FW'(CONFIRM - 1));
        take      = hit_open || hit_win || fwd_move;
        insert    = bit_en && locked_q && win_close && !seen_q && !hit_win;
        shifted   = take && (nxt != CW'(SYNC_END));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q      <= '0;
            cand_pos_q <= '0;
            cand_n_q   <= '0;
            cand_v_q   <= 1'b0;
            miss_q     <= '0;
            seen_q     <= 1'b0;
            locked_q   <= 1'b0;
        end else if (bit_en) begin
            cnt_q <= take ? CW'(SYNC_END) : nxt;

            // One boundary per window: remember an accepted sync until close.
            if (take) begin
                seen_q <= 1'b1;
            end else if (win_close) begin
                seen_q <= 1'b0;
            end

            // Rear protection: consecutive synthetic boundaries.
            if (take) begin
                locked_q <= 1'b1;
                miss_q   <= '0;
            end else if (insert) begin
                if (miss_q == MW'(LOSS_LIMIT - 1)) begin
                    locked_q <= 1'b0;
                    miss_q   <= '0;
                end else begin
                    miss_q <= miss_q + 1'b1;
                end
            end

            // Forward protection: one candidate position, confirmed per frame.
            if (shifted || !locked_q) begin
                cand_v_q <= 1'b0;
                cand_n_q <= '0;
            end else if (hit_out) begin
                if (cand_same) begin
                    cand_n_q <= cand_n_q + 1'b1;
                end else begin
                    cand_v_q   <= 1'b1;
                    cand_pos_q <= nxt;
                    cand_n_q   <= FW'(1);
                end
            end else if (cand_v_q && (nxt == cand_pos_q)) begin
                cand_v_q <= 1'b0;
                cand_n_q <= '0;
            end
        end
    end

    assign pos        = nxt;
    assign evt.take   = take;
    assign evt.insert = insert;
    assign locked     = locked_q;

endmodule

// File: rtl/fsync_symbols.sv
module fsync_symbols #(
    parameter int SYNC_BITS  = 24,
    parameter int MERGE_BITS = 3,
    parameter int SYM_BITS   = 14,
    parameter int NUM_SYMS   = 33,
    parameter int CW         = 10,
    parameter int IW         = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bit_en,
    input  logic [CW-1:0]       pos,
    input  logic                restart,
    input  logic                locked,
    input  logic [SYM_BITS-1:0] word_now,
    output logic                sym_valid,
    output logic [SYM_BITS-1:0] sym_word,
    output logic [IW-1:0]       sym_idx,
    output logic                sym_sub
);
    localparam int HDR_LAST = SYNC_BITS + MERGE_BITS - 1;
    localparam int SLOT     = SYM_BITS + MERGE_BITS;
    localparam int PW       = $clog2(SLOT);

    logic          run_q;
    logic [PW-1:0] ph_q;
    logic [IW-1:0] k_q;
    logic          emit;

    assign emit = bit_en && run_q && !restart && locked && (ph_q == PW'(SYM_BITS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            ph_q  <= '0;
            k_q   <= '0;
        end else if (bit_en) begin
            if (restart) begin
                run_q <= 1'b0;
            end else if (pos == CW'(HDR_LAST)) begin
                run_q <= 1'b1;
                ph_q  <= '0;
                k_q   <= '0;
            end else if (run_q) begin
                if (ph_q == PW'(SLOT - 1)) begin
                    ph_q <= '0;
                    if (k_q == IW'(NUM_SYMS - 1)) begin
                        run_q <= 1'b0;
                    end else begin
                        k_q <= k_q + 1'b1;
                    end
                end else begin
                    ph_q <= ph_q + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sym_valid <= 1'b0;
            sym_word  <= '0;
            sym_idx   <= '0;
            sym_sub   <= 1'b0;
        end else begin
            sym_valid <= emit;
            sym_sub   <= emit && (k_q == '0);
            if (emit) begin
                sym_word <= word_now;
                sym_idx  <= k_q;
            end
        end
    end

endmodule

// File: rtl/fsync_framer.sv
module fsync_framer
    import fsync_pkg::*;
#(
    parameter int                   SYNC_BITS    = DEF_SYNC_BITS,
    parameter int                   MERGE_BITS   = 3,
    parameter int                   SYM_BITS     = 14,
    parameter int                   NUM_SYMS     = 33,
    parameter int                   SYNC_WIN     = 2,
    parameter int                   LOSS_LIMIT   = 8,
    parameter int                   CONFIRM      = 3,
    parameter logic [SYNC_BITS-1:0] SYNC_PATTERN = DEF_SYNC_PATTERN
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         bit_en,
    input  logic                         bit_in,
    output logic                         frame_start,
    output logic                         frame_inserted,
    output logic                         locked,
    output logic                         sym_valid,
    output logic [SYM_BITS-1:0]          sym_word,
    output logic [$clog2(NUM_SYMS)-1:0]  sym_idx,
    output logic                         sym_sub
);
    localparam int FRAME_BITS = frame_len(SYNC_BITS, MERGE_BITS, SYM_BITS, NUM_SYMS);
    localparam int CW         = $clog2(FRAME_BITS);
    localparam int IDX_W      = $clog2(NUM_SYMS);

    logic                sync_hit;
    logic [SYM_BITS-1:0] word_now;
    logic [CW-1:0]       pos;
    fsync_evt_t          evt;

    fsync_shifter #(
        .SYNC_BITS(SYNC_BITS),
        .SYM_BITS (SYM_BITS),
        .PATTERN  (SYNC_PATTERN)
    ) u_shift (
        .clk     (clk),
        .rst     (rst),
        .bit_en  (bit_en),
        .bit_in  (bit_in),
        .sync_hit(sync_hit),
        .word_now(word_now)
    );

    fsync_timing #(
        .FRAME_BITS(FRAME_BITS),
        .SYNC_BITS (SYNC_BITS),
        .SYNC_WIN  (SYNC_WIN),
        .LOSS_LIMIT(LOSS_LIMIT),
        .CONFIRM   (CONFIRM),
        .CW        (CW)
    ) u_timing (
        .clk     (clk),
        .rst     (rst),
        .bit_en  (bit_en),
        .sync_hit(sync_hit),
        .pos     (pos),
        .evt     (evt),
        .locked  (locked)
    );

    fsync_symbols #(
        .SYNC_BITS (SYNC_BITS),
        .MERGE_BITS(MERGE_BITS),
        .SYM_BITS  (SYM_BITS),
        .NUM_SYMS  (NUM_SYMS),
        .CW        (CW),
        .IW        (IDX_W)
    ) u_syms (
        .clk      (clk),
        .rst      (rst),
        .bit_en   (bit_en),
        .pos      (pos),
        .restart  (evt.take),
        .locked   (locked),
        .word_now (word_now),
        .sym_valid(sym_valid),
        .sym_word (sym_word),
        .sym_idx  (sym_idx),
        .sym_sub  (sym_sub)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_start    <= 1'b0;
            frame_inserted <= 1'b0;
        end else begin
            frame_start    <= evt.take || evt.insert;
            frame_inserted <= evt.insert;
        end
    end

endmodule

// File: rtl/fsync_framer_chk.sv
module fsync_framer_chk #(
    parameter int NUM_SYMS = 33,
    parameter int IDX_W    = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             bit_en,
    input logic             frame_start,
    input logic             frame_inserted,
    input logic             locked,
    input logic             sym_valid,
    input logic [IDX_W-1:0] sym_idx,
    input logic             sym_sub
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> (!locked && !frame_start && !frame_inserted && !sym_valid));

    assert_strobe_needs_bit_R2: assert property (@(posedge clk) disable iff (rst)
        (frame_start || sym_valid) |-> $past(bit_en));

    assert_lock_by_real_sync_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> (frame_start && !frame_inserted));

    assert_insert_is_start_R5: assert property (@(posedge clk) disable iff (rst)
        frame_inserted |-> frame_start);

    assert_idx_in_range_R6: assert property (@(posedge clk) disable iff (rst)
        sym_valid |-> (int'(sym_idx) < NUM_SYMS));

    assert_sub_first_R7: assert property (@(posedge clk) disable iff (rst)
        sym_sub |-> (sym_valid && (sym_idx == '0)));

    assert_first_is_sub_R7: assert property (@(posedge clk) disable iff (rst)
        (sym_valid && (sym_idx == '0)) |-> sym_sub);

    assert_symbols_locked_R8: assert property (@(posedge clk) disable iff (rst)
        sym_valid |-> locked);

    assert_loss_on_insert_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(locked) |-> frame_inserted);

    assert_no_overlap_R10: assert property (@(posedge clk) disable iff (rst)
        !(frame_start && sym_valid));

endmodule

bind fsync_framer fsync_framer_chk #(
    .NUM_SYMS(NUM_SYMS),
    .IDX_W   (IDX_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .bit_en        (bit_en),
    .frame_start   (frame_start),
    .frame_inserted(frame_inserted),
    .locked        (locked),
    .sym_valid     (sym_valid),
    .sym_idx       (sym_idx),
    .sym_sub       (sym_sub)
);

// File: tb/test_fsync_framer.sv
`timescale 1ns/1ps
module test_fsync_framer;
    localparam int NSYM  = 4;
    localparam int SYNCB = 24;
    localparam int SYMB  = 14;
    localparam int WIN   = 2;
    localparam int LOSS  = 6;
    localparam int CONF  = 3;
    localparam int IDXW  = $clog2(NSYM);
    localparam logic [23:0] PAT = 24'b1000_0000_0001_0000_0000_0010;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            bit_en = 1'b0;
    logic            bit_in = 1'b0;
    logic            frame_start, frame_inserted, locked, sym_valid, sym_sub;
    logic [SYMB-1:0] sym_word;
    logic [IDXW-1:0] sym_idx;

    always #2.5 clk = ~clk;

    fsync_framer #(
        .NUM_SYMS  (NSYM),
        .SYNC_WIN  (WIN),
        .LOSS_LIMIT(LOSS),
        .CONFIRM   (CONF)
    ) i_fsync_framer (
        .clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in),
        .frame_start(frame_start), .frame_inserted(frame_inserted), .locked(locked),
        .sym_valid(sym_valid), .sym_word(sym_word), .sym_idx(sym_idx), .sym_sub(sym_sub)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [SYMB-1:0] exp_word [NSYM];
    int ev_fs = 0, ev_ins = 0, ev_sym = 0, ev_bad = 0;

    // Event monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (!rst) begin
            if (frame_start)    ev_fs++;
            if (frame_inserted) ev_ins++;
            if (sym_valid) begin
                if (int'(sym_idx) != ev_sym || sym_word != exp_word[sym_idx] ||
                    sym_sub != (sym_idx == '0))
                    ev_bad++;
                ev_sym++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [SYMB-1:0] mkword(input int seed, input int k);
        return SYMB'((seed * 113) + (k * 29) + (seed * k * 7)) | 14'h1111;
    endfunction

    task automatic push(input logic b);
        @(negedge clk);
        bit_en = 1'b1;
        bit_in = b;
        @(negedge clk);
        bit_en = 1'b0;
        bit_in = 1'($urandom_range(0, 1));
    endtask

    task automatic push_merge(input int keep);
        if (keep > 0) push(1'b0);
        if (keep > 1) push(1'b1);
        if (keep > 2) push(1'b0);
    endtask

    task automatic send_frame(input int seed, input int pre, input int trunc, input bit has_sync);
        for (int k = 0; k < NSYM; k++) exp_word[k] = mkword(seed, k);
        ev_fs = 0; ev_ins = 0; ev_sym = 0; ev_bad = 0;
        for (int i = 0; i < pre; i++) push(1'b1);
        for (int i = SYNCB - 1; i >= 0; i--) push(has_sync ? PAT[i] : 1'(i % 2));
        push_merge(3);
        for (int k = 0; k < NSYM; k++) begin
            for (int b = SYMB - 1; b >= 0; b--) push(exp_word[k][b]);
            push_merge((k == NSYM - 1) ? 3 - trunc : 3);
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic frame_check(input string req, input int efs, input int eins,
                               input int esym, input bit elock, input bit words);
        chk(ev_fs == efs, req, "frame strobes", ev_fs, efs);
        chk(ev_ins == eins, req, "inserted strobes", ev_ins, eins);
        chk(ev_sym == esym, req, "symbols", ev_sym, esym);
        chk(locked == elock, req, "locked", int'(locked), int'(elock));
        if (words) chk(ev_bad == 0, req, "symbol word/index/sub mismatches", ev_bad, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (4) @(negedge clk);
        chk(!locked && !frame_start && !frame_inserted && !sym_valid, "R1", "outputs in reset",
            int'({locked, frame_start, frame_inserted, sym_valid}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!locked && !frame_start && !sym_valid, "R1", "outputs after reset",
            int'({locked, frame_start, sym_valid}), 0);

        // R2: sync pattern driven with bit_en low is ignored
        ev_fs = 0; ev_sym = 0;
        for (int r = 0; r < 2; r++)
            for (int i = SYNCB - 1; i >= 0; i--) begin
                @(negedge clk);
                bit_in = PAT[i];
            end
        repeat (2) @(negedge clk);
        chk(ev_fs == 0 && ev_sym == 0, "R2", "events with bit_en low", ev_fs + ev_sym, 0);
        chk(!locked, "R2", "locked with bit_en low", int'(locked), 0);

        // R3/R6/R7: acquisition from unlocked, then a sweep of data seeds
        send_frame(1, 0, 0, 1'b1);
        frame_check("R3", 1, 0, NSYM, 1'b1, 1'b1);
        for (int s = 2; s < 10; s++) begin
            send_frame(s, 0, 0, 1'b1);
            frame_check("R6 R7", 1, 0, NSYM, 1'b1, 1'b1);
        end

        // R4: late syncs inside the window
        for (int d = 1; d <= WIN; d++) begin
            send_frame(20 + d, d, 0, 1'b1);
            frame_check("R4 late", 1, 0, NSYM, 1'b1, 1'b1);
        end
        // R4: early syncs inside the window
        for (int d = 1; d <= WIN; d++) begin
            send_frame(30 + d, 0, d, 1'b1);
            frame_check("R4 pre", 1, 0, NSYM, 1'b1, 1'b1);
            send_frame(40 + d, 0, 0, 1'b1);
            frame_check("R4 early", 1, 0, NSYM, 1'b1, 1'b1);
        end

        // R9: sync moved just outside the window, confirmed on third frame
        send_frame(50, WIN + 1, 0, 1'b1);
        frame_check("R9 sighting1", 1, 1, NSYM, 1'b1, 1'b0);
        send_frame(51, 0, 0, 1'b1);
        frame_check("R9 sighting2", 1, 1, NSYM, 1'b1, 1'b0);
        send_frame(52, 0, 0, 1'b1);
        frame_check("R9 R10 move", 2, 1, NSYM, 1'b1, 1'b1);
        send_frame(53, 0, 0, 1'b1);
        frame_check("R9 after move", 1, 0, NSYM, 1'b1, 1'b1);

        // R9: confirmation interrupted by a frame without a sighting
        send_frame(60, 5, 0, 1'b1);
        frame_check("R9 far1", 1, 1, NSYM, 1'b1, 1'b0);
        send_frame(61, 0, 0, 1'b0);
        frame_check("R9 gap", 1, 1, NSYM, 1'b1, 1'b0);
        send_frame(62, 0, 0, 1'b1);
        frame_check("R9 restart1", 1, 1, NSYM, 1'b1, 1'b0);
        send_frame(63, 0, 0, 1'b1);
        frame_check("R9 restart2 no move", 1, 1, NSYM, 1'b1, 1'b0);
        send_frame(64, 0, 0, 1'b1);
        frame_check("R9 restart3 move", 2, 1, NSYM, 1'b1, 1'b1);
        send_frame(65, 0, 0, 1'b1);
        frame_check("R9 settled", 1, 0, NSYM, 1'b1, 1'b1);

        // R5/R8: missing syncs are inserted until lock is lost
        for (int m = 1; m < LOSS; m++) begin
            send_frame(70 + m, 0, 0, 1'b0);
            frame_check("R5 inserted", 1, 1, NSYM, 1'b1, 1'b1);
        end
        send_frame(80, 0, 0, 1'b0);
        frame_check("R8 loss", 1, 1, 0, 1'b0, 1'b0);
        send_frame(81, 0, 0, 1'b0);
        frame_check("R8 unlocked quiet", 0, 0, 0, 1'b0, 1'b0);
        send_frame(82, 7, 0, 1'b1);
        frame_check("R3 relock open window", 1, 0, NSYM, 1'b1, 1'b1);
        send_frame(83, 0, 0, 1'b1);
        frame_check("R6 after relock", 1, 0, NSYM, 1'b1, 1'b1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule